// File: doc/BRIEF.md
# System Interrupt Router with Level Mapping

This block collects 32 device interrupt lines into a level-following pending register and turns them into processor priority levels for a small multiprocessor system. Each source bit is translated to one of fifteen processor levels through a fixed, irregular table. Several sources may share a level, and some sources map to no level at all. The resulting set of hard levels is delivered to a single target processor chosen by software. Every other processor sees none of them.

Software controls the router through a word-wide register window. It can read pending, read the disable mask, enable sources with a write-one-to-clear, disable them with a write-one-to-set, and read or write the target processor number. Disabling a source only masks it and leaves its pending bit alone. Bit 31 of the disable mask is a master switch. Besides the hard levels, each processor gets a level-14 request from its own timer line and a level-15 request whenever any level-15 source is high. That level-15 request goes to every processor and ignores the per-source mask. The master switch silences all of it.

Top module: `sys_irq_router`

## Requirements
- R1: After reset the pending read (offset 0) is 0, the disable read (offset 1) is 0, the target read (offset 4) is 0 and every processor level output is 0.
- R2: Pending bit b equals source line b as sampled on the previous clock edge, for every source whose table level is nonzero. Sources 23 to 26 and 31 map to level 0 and never show as pending, and bit 31 of the pending read is always 0.
- R3: A write to offset 3 sets, and a write to offset 2 clears, the disable bits selected by ones in the data. Only bits in the mask 0xF05DFF80 can change. Bits in 0x0FA2007F stay set internally. The offset 1 read returns the disable register ANDed with 0xF05DFF80.
- R4: A write to offset 4 stores the data modulo 16 as the target, and the offset 4 read returns it in bits 3:0 with the upper bits zero.
- R5: On the target processor only, output bit L is set when some pending, non-disabled source maps to level L. The map from bit 0 upward is 2,3,5,7,9,11,13,2,3,5,7,9,11,13,12,12,6,13,4,10,8,9,11,0,0,0,0,15,15,15,15,0. Sources that share a level are ORed together. The outputs reflect the register state of the previous edge, so a source edge reaches the output two clocks later.
- R6: Setting a disable bit masks the source's level but never clears its pending bit.
- R7: While disable bit 31 is set, every level output of every processor is 0, including timer and level-15 requests.
- R8: While any of sources 27 to 30 is high and bit 31 is clear, output bit 15 is set on every processor, whatever their per-source disable bits.
- R9: Timer input i sets output bit 14 of processor i only, while bit 31 is clear.
- R10: Output bit 0 of every processor is never set. A target value with no matching processor delivers hard levels to none.
- R11: Writes to offsets 0, 1, 5, 6 and 7 change no register. Reads of offsets 2, 3, 5, 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_irq | input | 32 | Device interrupt lines, active high, level |
| cpu_timer | input | NUM_CPU | Per-processor timer request lines |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr, combinational |
| cpu_irl | output | NUM_CPU*16 | Level set per processor; processor c owns bits 16c+15:16c |

## Verification
On every cycle the assertions check several things. Pending follows the lines with one edge of delay. The fixed-off disable bits never drop. A target write lands modulo 16. A set master bit leaves every output at zero. A processor that was not the target shows none of levels 1 to 13. Only the bench's scenarios can show the level mapping itself, source by source, for every target. The same goes for sharing of a level between sources, the broadcast of level 15 despite a per-source disable, timer steering, pending surviving a disable, and the two-clock latency from a source edge to an output.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
   localparam int SRC_W  = 32;
   localparam int LVL_W  = 16;
   localparam int TGT_W  = 4;
   localparam int ADDR_W = 3;
   localparam int MASTER_BIT = 31;
   localparam logic [SRC_W-1:0] FIXED_OFF = 32'h0FA2_007F;
   localparam logic [SRC_W-1:0] DIS_VALID = ~FIXED_OFF;

   typedef enum logic [ADDR_W-1:0] {
      OFS_PEND = 3'd0,
      OFS_DIS  = 3'd1,
      OFS_EN   = 3'd2,
      OFS_MASK = 3'd3,
      OFS_TGT  = 3'd4
   } reg_ofs_e;

   // Processor level reached by each source bit; 0 means unrouted.
   function automatic logic [3:0] src_level(input int unsigned b);
      case (b)
         0, 7:            return 4'd2;
         1, 8:            return 4'd3;
         2, 9:            return 4'd5;
         3, 10:           return 4'd7;
         4, 11, 21:       return 4'd9;
         5, 12, 22:       return 4'd11;
         6, 13, 17:       return 4'd13;
         14, 15:          return 4'd12;
         16:              return 4'd6;
         18:              return 4'd4;
         19:              return 4'd10;
         20:              return 4'd8;
         27, 28, 29, 30:  return 4'd15;
         default:         return 4'd0;
      endcase
   endfunction

   function automatic logic [SRC_W-1:0] routed_mask();
      logic [SRC_W-1:0] m;
      m = '0;
      for (int b = 0; b < SRC_W; b++) m[b] = (src_level(b) != 4'd0);
      return m;
   endfunction

   function automatic logic [SRC_W-1:0] top_level_mask();
      logic [SRC_W-1:0] m;
      m = '0;
      for (int b = 0; b < SRC_W; b++) m[b] = (src_level(b) == 4'd15);
      return m;
   endfunction
endpackage

// File: rtl/sirq_regs.sv
module sirq_regs
   import sirq_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [SRC_W-1:0]    src_irq,
   input  logic [NUM_CPU-1:0]  cpu_timer,
   input  logic                reg_wr,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [SRC_W-1:0]    reg_wdata,
   output logic [SRC_W-1:0]    reg_rdata,
   output logic [SRC_W-1:0]    pend_q,
   output logic [SRC_W-1:0]    dis_q,
   output logic [TGT_W-1:0]    tgt_q,
   output logic [NUM_CPU-1:0]  tmr_q
);
   localparam logic [SRC_W-1:0] ROUTED = routed_mask();

   logic wr_en, wr_mask, wr_tgt;
   assign wr_en   = reg_wr && (reg_addr == OFS_EN);
   assign wr_mask = reg_wr && (reg_addr == OFS_MASK);
   assign wr_tgt  = reg_wr && (reg_addr == OFS_TGT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         tmr_q  <= '0;
      end else begin
         pend_q <= src_irq & ROUTED;
         tmr_q  <= cpu_timer;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dis_q <= FIXED_OFF;
      end else if (wr_en) begin
         dis_q <= dis_q & ~(reg_wdata & DIS_VALID);
      end else if (wr_mask) begin
         dis_q <= dis_q | (reg_wdata & DIS_VALID);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tgt_q <= '0;
      else if (wr_tgt) tgt_q <= reg_wdata[TGT_W-1:0];
   end

   always_comb begin
      unique case (reg_addr)
         OFS_PEND: reg_rdata = pend_q & ~(SRC_W'(1) << MASTER_BIT);
         OFS_DIS:  reg_rdata = dis_q & DIS_VALID;
         OFS_TGT:  reg_rdata = {{(SRC_W-TGT_W){1'b0}}, tgt_q};
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/sirq_level_map.sv
module sirq_level_map
   import sirq_pkg::*;
(
   input  logic [SRC_W-1:0] hard_src,
   output logic [LVL_W-1:0] hard_lvl
);
   logic [LVL_W-1:0] contrib [SRC_W];

   for (genvar b = 0; b < SRC_W; b++) begin : g_src
      localparam logic [3:0] LV = src_level(b);
      if (LV != 4'd0) begin : g_routed
         assign contrib[b] = hard_src[b] ? (LVL_W'(1) << LV) : '0;
      end else begin : g_unrouted
         assign contrib[b] = '0;
      end
   end

   always_comb begin
      hard_lvl = '0;
      for (int b = 0; b < SRC_W; b++) hard_lvl |= contrib[b];
   end
endmodule

// File: rtl/sirq_cpu_port.sv
module sirq_cpu_port
   import sirq_pkg::*;
#(
   parameter int CPU_ID = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LVL_W-1:0] hard_lvl,
   input  logic [TGT_W-1:0] tgt,
   input  logic             master_off,
   input  logic             bcast15,
   input  logic             timer,
   output logic [LVL_W-1:0] irl_q
);
   logic             is_tgt;
   logic [LVL_W-1:0] local_lvl, irl_d;

   assign is_tgt    = (tgt == TGT_W'(CPU_ID));
   assign local_lvl = {bcast15, timer, {(LVL_W-2){1'b0}}};
   assign irl_d     = master_off ? '0
                    : (((is_tgt ? hard_lvl : '0) | local_lvl) & ~LVL_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irl_q <= '0;
      else        irl_q <= irl_d;
   end
endmodule

// File: rtl/sys_irq_router.sv
module sys_irq_router
   import sirq_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [31:0]               src_irq,
   input  logic [NUM_CPU-1:0]        cpu_timer,
   input  logic                      reg_wr,
   input  logic [2:0]                reg_addr,
   input  logic [31:0]               reg_wdata,
   output logic [31:0]               reg_rdata,
   output logic [NUM_CPU*16-1:0]     cpu_irl
);
   localparam logic [SRC_W-1:0] TOP_SRC = top_level_mask();

   if (NUM_CPU < 1 || NUM_CPU > (1 << TGT_W)) begin : g_bad_cfg
      $error("sys_irq_router: NUM_CPU must be 1..16");
   end

   logic [SRC_W-1:0]   pend_q, dis_q;
   logic [TGT_W-1:0]   tgt_q;
   logic [NUM_CPU-1:0] tmr_q;
   logic [LVL_W-1:0]   hard_lvl;
   logic               bcast15;

   sirq_regs #(.NUM_CPU(NUM_CPU)) u_regs (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cpu_timer(cpu_timer),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .pend_q(pend_q), .dis_q(dis_q),
      .tgt_q(tgt_q), .tmr_q(tmr_q)
   );

   sirq_level_map u_map (
      .hard_src(pend_q & ~dis_q),
      .hard_lvl(hard_lvl)
   );

   assign bcast15 = |(pend_q & TOP_SRC);

   for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
      sirq_cpu_port #(.CPU_ID(c)) u_port (
         .clk(clk), .rst_n(rst_n), .hard_lvl(hard_lvl), .tgt(tgt_q),
         .master_off(dis_q[MASTER_BIT]), .bcast15(bcast15),
         .timer(tmr_q[c]), .irl_q(cpu_irl[c*LVL_W +: LVL_W])
      );
   end
endmodule

// File: rtl/sirq_router_chk.sv
module sirq_router_chk
   import sirq_pkg::*;
#(
   parameter int NUM_CPU = 4
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [31:0]           src_irq,
   input logic                  reg_wr,
   input logic [2:0]            reg_addr,
   input logic [31:0]           reg_wdata,
   input logic [31:0]           pend_q,
   input logic [31:0]           dis_q,
   input logic [3:0]            tgt_q,
   input logic [NUM_CPU*16-1:0] cpu_irl
);
   localparam logic [31:0] ROUTED = routed_mask();

   // R2: pending tracks the routed lines with one edge of delay
   p_pend_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> pend_q == ($past(src_irq) & ROUTED));

   // R3: bits outside the writable mask never leave their reset value
   p_fixed_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (dis_q & FIXED_OFF) == FIXED_OFF);

   // R4: target write keeps the value modulo 16
   p_target_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == 3'd4) |=> tgt_q == $past(reg_wdata[3:0]));

   // R7: master disable silences every processor on the next edge
   p_master_block_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(dis_q[31])) |-> cpu_irl == '0);

   // R5: levels 1..13 appear only on the processor that was the target
   for (genvar c = 0; c < NUM_CPU; c++) begin : g_nt
      p_nontarget_r5: assert property (@(posedge clk) disable iff (!rst_n)
         ($past(rst_n) && $past(tgt_q) != 4'(c)) |-> cpu_irl[c*16+1 +: 13] == '0);
   end
endmodule

bind sys_irq_router sirq_router_chk #(.NUM_CPU(NUM_CPU)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .reg_wr(reg_wr),
   .reg_addr(reg_addr), .reg_wdata(reg_wdata), .pend_q(pend_q),
   .dis_q(dis_q), .tgt_q(tgt_q), .cpu_irl(cpu_irl)
);

// File: tb/tb_sys_irq_router.sv
module tb_sys_irq_router;
   localparam int CLK_PERIOD = 10;
   localparam int NCPU = 4;
   localparam logic [31:0] VALID = 32'hF05D_FF80;
   localparam logic [31:0] FIXED = 32'h0FA2_007F;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [31:0]          src_irq = '0;
   logic [NCPU-1:0]      cpu_timer = '0;
   logic                 reg_wr = 1'b0;
   logic [2:0]           reg_addr = '0;
   logic [31:0]          reg_wdata = '0;
   logic [31:0]          reg_rdata;
   logic [NCPU*16-1:0]   cpu_irl;

   int checks = 0;
   int failures = 0;
   logic [31:0] dis_m;
   logic [3:0]  tgt_m;

   // Level table from R5, indexed by source bit
   int lvl_tab [32] = '{2,3,5,7,9,11,13,2, 3,5,7,9,11,13,12,12,
                        6,13,4,10,8,9,11,0, 0,0,0,15,15,15,15,0};

   always #(CLK_PERIOD/2) clk = ~clk;

   sys_irq_router #(.NUM_CPU(NCPU)) dut (
      .clk(clk), .rst_n(rst_n), .src_irq(src_irq), .cpu_timer(cpu_timer),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .cpu_irl(cpu_irl)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] pend_exp(input logic [31:0] s);
      logic [31:0] p = '0;
      for (int b = 0; b < 32; b++) if (s[b] && lvl_tab[b] != 0) p[b] = 1'b1;
      return p;
   endfunction

   function automatic logic [NCPU*16-1:0] irl_exp(input logic [31:0] s,
      input logic [31:0] d, input logic [3:0] t, input logic [NCPU-1:0] tm);
      logic [NCPU*16-1:0] r = '0;
      if (!d[31]) begin
         for (int c = 0; c < NCPU; c++) begin
            for (int b = 0; b < 32; b++) begin
               if (s[b] && lvl_tab[b] != 0 && !d[b] && t == 4'(c))
                  r[c*16 + lvl_tab[b]] = 1'b1;
               if (s[b] && lvl_tab[b] == 15) r[c*16 + 15] = 1'b1;
            end
            if (tm[c]) r[c*16 + 14] = 1'b1;
         end
      end
      return r;
   endfunction

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
      if (a == 3'd2) dis_m = dis_m & ~(v & VALID);
      if (a == 3'd3) dis_m = dis_m | (v & VALID);
      if (a == 3'd4) tgt_m = v[3:0];
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic chk_all(input string req);
      logic [31:0] v;
      rd(3'd0, v);
      chk({req, " pending"}, 64'(v), 64'(pend_exp(src_irq)));
      chk({req, " levels"}, 64'(cpu_irl), 64'(irl_exp(src_irq, dis_m, tgt_m, cpu_timer)));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [31:0] v;
      dis_m = FIXED; tgt_m = 4'd0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(3'd0, v); chk("R1 pending", 64'(v), 64'h0);
      rd(3'd1, v); chk("R1 disable", 64'(v), 64'h0);
      rd(3'd4, v); chk("R1 target", 64'(v), 64'h0);
      chk("R1 levels", 64'(cpu_irl), 64'h0);

      // R2 R5 R8 R10: one source at a time, over several targets
      for (int ti = 0; ti < 5; ti++) begin
         wr(3'd4, (ti == 4) ? 32'd5 : 32'(ti));
         for (int b = 0; b < 32; b++) begin
            @(negedge clk); src_irq = 32'(1) << b;
            settle();
            chk_all("R2_R5_R8_R10 sweep");
         end
         @(negedge clk); src_irq = '0;
         settle();
      end

      // R5 latency: source edge -> pending after 1 clock, level after 2
      wr(3'd4, 32'd0);
      @(negedge clk); src_irq = 32'h0000_1000;
      @(negedge clk);
      rd(3'd0, v); chk("R5 latency pending", 64'(v), 64'h1000);
      chk("R5 latency level early", 64'(cpu_irl[11]), 64'h0);
      @(negedge clk);
      chk("R5 latency level", 64'(cpu_irl[15:0]), 64'h0800);

      // R5 sharing: sources 12 and 22 both at level 11
      src_irq = 32'h0040_1000; settle(); chk_all("R5 shared both");
      wr(3'd3, 32'h0000_1000); settle(); chk_all("R5 shared one masked");
      wr(3'd3, 32'h0040_0000); settle(); chk_all("R5 shared both masked");
      wr(3'd2, 32'h0040_1000); settle(); chk_all("R5 shared re-enabled");

      // R6: disabling keeps pending
      src_irq = 32'h0000_0200; settle();
      wr(3'd3, 32'h0000_0200); settle();
      chk_all("R6 masked source");
      rd(3'd0, v); chk("R6 pending kept", 64'(v), 64'h200);
      wr(3'd2, 32'h0000_0200); settle();
      chk("R6 re-enable level", 64'(cpu_irl[15:0]), 64'h0020);

      // R8: level-15 broadcast ignores per-source mask
      wr(3'd3, 32'h1000_0000);
      @(negedge clk); src_irq = 32'h1000_0000; settle();
      chk("R8 broadcast", 64'(cpu_irl), 64'h8000_8000_8000_8000);
      wr(3'd2, 32'h1000_0000);

      // R9: timers steered to their own processor
      src_irq = '0;
      for (int c = 0; c < NCPU; c++) begin
         @(negedge clk); cpu_timer = NCPU'(1) << c; settle();
         chk("R9 timer", 64'(cpu_irl), 64'(1) << (c*16 + 14));
      end
      cpu_timer = '0;

      // R3 R7: master disable blocks everything, pending still visible (R6)
      wr(3'd3, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R3 disable set", 64'(v), 64'hF05D_FF80);
      @(negedge clk); src_irq = 32'hFFFF_FFFF; cpu_timer = '1; settle();
      chk("R7 master blocks", 64'(cpu_irl), 64'h0);
      rd(3'd0, v); chk("R6 pending under master", 64'(v), 64'(pend_exp(32'hFFFF_FFFF)));
      rd(3'd0, v); chk("R2 bit31 zero", 64'(v[31]), 64'h0);
      wr(3'd2, 32'h7FFF_FFFF);
      rd(3'd1, v); chk("R3 partial clear", 64'(v), 64'h8000_0000);
      settle(); chk("R7 still blocked", 64'(cpu_irl), 64'h0);
      wr(3'd2, 32'h8000_0000);
      rd(3'd1, v); chk("R3 clear master", 64'(v), 64'h0);
      settle(); chk_all("R7 released");
      @(negedge clk); src_irq = '0; cpu_timer = '0; settle();

      // R4: target modulo 16
      wr(3'd4, 32'h0000_0013);
      rd(3'd4, v); chk("R4 target mod", 64'(v), 64'h3);
      wr(3'd4, 32'hFFFF_FFFF);
      rd(3'd4, v); chk("R4 target max", 64'(v), 64'hF);
      @(negedge clk); src_irq = 32'h0000_0100; settle();
      chk_all("R10 target without processor");
      wr(3'd4, 32'd1);

      // R11: unused offsets
      foreach (v[i]) ;
      wr(3'd0, 32'hFFFF_FFFF); wr(3'd1, 32'hFFFF_FFFF);
      wr(3'd5, 32'hFFFF_FFFF); wr(3'd6, 32'hFFFF_FFFF); wr(3'd7, 32'hFFFF_FFFF);
      rd(3'd1, v); chk("R11 disable unchanged", 64'(v), 64'h0);
      rd(3'd4, v); chk("R11 target unchanged", 64'(v), 64'h1);
      for (int a = 2; a < 8; a++) begin
         if (a != 4) begin
            rd(3'(a), v); chk("R11 read zero", 64'(v), 64'h0);
         end
      end
      settle(); chk_all("R11 levels unchanged");

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule